// File: doc/BRIEF.md
# Ordered Write Buffer with Read Bypass

This block sits between a processor core and one system bus port. Core writes are placed in a small FIFO write buffer and drained to the bus one at a time. Core reads that hit the cache and are not I/O are answered on the spot with the data the core supplies, and never touch the bus. Read misses go to the bus and return the bus read data.

Bus traffic normally follows the order in which the core issued its accesses. There is one exception. A read miss may be sent ahead of older buffered writes. This is allowed only when every buffered write is a cache hit, none of them is an I/O write, and none of them carries the read's word address. I/O reads are never reordered.

On the bus side, a request is held until it is accepted by a valid/ready handshake. A one-cycle response then carries the read data or the write acknowledge. Only one transaction is ever in flight.

Top module: `wrbuf_bypass`

## Requirements
- R1: Buffered writes reach the bus in the order the core handed them over, with the same address and data. An entry leaves the buffer in the cycle after its acknowledge.
- R2: The buffer holds DEPTH entries (4 by default). `coreWrReady` is high exactly when fewer than DEPTH entries are held and no read is pending on `coreRdValid`. When a read and a write are presented together, the read counts as the older access.
- R3: A read with `coreRdHit`=1 and `coreRdIo`=0 raises `coreRdDone` in the same cycle, with `coreRdData` equal to `coreRdHitData`, and issues nothing on the bus.
- R4: A non-I/O read miss is requested on the bus while the buffer is not empty only if every held entry has hit=1 and io=0 and no held entry has the same 32-bit address. Otherwise it waits until the buffer is empty.
- R5: An I/O read (`coreRdIo`=1) is requested on the bus only when the write buffer is empty.
- R6: If the bus is idle and a bypass-eligible read miss is pending while writes are buffered, the next bus request is that read.
- R7: From a request handshake until its response, `busReqValid` stays low, so at most one transaction is outstanding.
- R8: For a read miss, `coreRdDone` is high in the cycle that `busRspValid` returns the read, with `coreRdData` equal to `busRspData`. Otherwise `coreRdDone` is high only in the case of R3.
- R9: Once `busReqValid` is raised, it stays high with stable `busReqWrite`, `busReqAddr` and `busReqData` until `busReqReady` is seen.
- R10: A synchronous active-high `rst` empties the buffer and leaves `busReqValid` low. After reset, `coreWrReady` is high while no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coreWrValid | input | 1 | Core write request |
| coreWrReady | output | 1 | Write accepted into buffer this cycle |
| coreWrAddr | input | 32 | Write word address |
| coreWrData | input | 32 | Write data |
| coreWrHit | input | 1 | Write hits the cache |
| coreWrIo | input | 1 | Write is an I/O access |
| coreRdValid | input | 1 | Read request, held until `coreRdDone` |
| coreRdAddr | input | 32 | Read word address |
| coreRdHit | input | 1 | Read hits the cache |
| coreRdIo | input | 1 | Read is an I/O access |
| coreRdHitData | input | 32 | Cache data for a hitting read |
| coreRdDone | output | 1 | Read complete this cycle |
| coreRdData | output | 32 | Read result, valid with `coreRdDone` |
| busReqValid | output | 1 | Bus request valid |
| busReqReady | input | 1 | Bus accepts request |
| busReqWrite | output | 1 | 1 = write, 0 = read |
| busReqAddr | output | 32 | Request address |
| busReqData | output | 32 | Write data (0 on reads) |
| busRspValid | input | 1 | One-cycle response: read data or write acknowledge |
| busRspData | input | 32 | Read data |

## Verification
The assertions watch several rules on every cycle: request holding on the bus, the single outstanding transaction, the fast completion of hitting reads, write stalls while a read is pending or the buffer is full, I/O reads leaving only from an empty buffer, and read completion on the response. Other rules only show up across whole scenarios. These are FIFO drain order and data, the bypass eligibility test against buffered addresses and flags, and the read winning the bus over a waiting write. The bench checks them against its own model of pending writes, using directed cases for match, miss, I/O and priority, and random traffic on a small address set.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

  // Control -> datapath strobes
  typedef struct packed {
    logic push;
    logic pop;
    logic selRead;
    logic fastHit;
  } wbStrobe_t;

  // Datapath -> control status
  typedef struct packed {
    logic empty;
    logic full;
    logic allClean;
    logic addrHit;
  } wbStatus_t;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_REQ  = 2'd1,
    BUS_WAIT = 2'd2
  } busState_t;

endpackage

// File: rtl/wrbuf_dp.sv
module wrbuf_dp
  import wrbuf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  wbStrobe_t     strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          wrHit,
  input  logic          wrIo,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] rdHitData,
  input  logic [DW-1:0] rspData,
  output wbStatus_t     status,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busData,
  output logic [DW-1:0] rdData
);

  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0]    addrMem [DEPTH];
  logic [DW-1:0]    dataMem [DEPTH];
  logic [DEPTH-1:0] hitMem;
  logic [DEPTH-1:0] ioMem;
  logic [DEPTH-1:0] vld;
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;
  logic [DEPTH-1:0] matchVec;
  logic [DEPTH-1:0] dirtyVec;

  // Occupancy and pointers
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) begin
        vld[wrPtr] <= 1'b1;
        wrPtr      <= wrPtr + 1'b1;
      end
      if (strobe.pop) begin
        vld[rdPtr] <= 1'b0;
        rdPtr      <= rdPtr + 1'b1;
      end
    end
  end

  // Entry payload, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[wrPtr] <= wrAddr;
      dataMem[wrPtr] <= wrData;
      hitMem[wrPtr]  <= wrHit;
      ioMem[wrPtr]   <= wrIo;
    end
  end

  // Parallel per-entry compare for the bypass decision
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign matchVec[i] = vld[i] && (addrMem[i] == rdAddr);
    assign dirtyVec[i] = vld[i] && (!hitMem[i] || ioMem[i]);
  end

  always_comb begin
    status.empty    = ~|vld;
    status.full     = &vld;
    status.allClean = ~|dirtyVec;
    status.addrHit  = |matchVec;
    busAddr = strobe.selRead ? rdAddr : addrMem[rdPtr];
    busData = strobe.selRead ? '0     : dataMem[rdPtr];
    rdData  = strobe.fastHit ? rdHitData : rspData;
  end

endmodule

// File: rtl/wrbuf_ctl.sv
module wrbuf_ctl
  import wrbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  wbStatus_t status,
  input  logic      coreWrValid,
  input  logic      coreRdValid,
  input  logic      coreRdHit,
  input  logic      coreRdIo,
  input  logic      busReqReady,
  input  logic      busRspValid,
  output wbStrobe_t strobe,
  output logic      coreWrReady,
  output logic      coreRdDone,
  output logic      busReqValid,
  output logic      busReqWrite
);

  busState_t state;
  logic      kindRd;
  logic      fastHit;
  logic      rdMiss;
  logic      bypassOk;
  logic      rdGo;
  logic      rspHere;

  always_comb begin
    fastHit  = coreRdValid && coreRdHit && !coreRdIo;
    rdMiss   = coreRdValid && !fastHit;
    bypassOk = !coreRdIo && status.allClean && !status.addrHit;
    rdGo     = rdMiss && (status.empty || bypassOk);
    rspHere  = (state == BUS_WAIT) && busRspValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= BUS_IDLE;
      kindRd <= 1'b0;
    end else begin
      unique case (state)
        BUS_IDLE: begin
          if (rdGo) begin
            state  <= BUS_REQ;
            kindRd <= 1'b1;
          end else if (!status.empty) begin
            state  <= BUS_REQ;
            kindRd <= 1'b0;
          end
        end
        BUS_REQ:  if (busReqReady) state <= BUS_WAIT;
        BUS_WAIT: if (busRspValid) state <= BUS_IDLE;
        default:  state <= BUS_IDLE;
      endcase
    end
  end

  always_comb begin
    coreWrReady    = !status.full && !coreRdValid;
    strobe.push    = coreWrValid && coreWrReady;
    strobe.pop     = rspHere && !kindRd;
    strobe.selRead = kindRd;
    strobe.fastHit = fastHit;
    coreRdDone     = fastHit || (rspHere && kindRd);
    busReqValid    = (state == BUS_REQ);
    busReqWrite    = !kindRd;
  end

endmodule

// File: rtl/wrbuf_bypass.sv
module wrbuf_bypass
  import wrbuf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          coreWrValid,
  output logic          coreWrReady,
  input  logic [AW-1:0] coreWrAddr,
  input  logic [DW-1:0] coreWrData,
  input  logic          coreWrHit,
  input  logic          coreWrIo,
  input  logic          coreRdValid,
  input  logic [AW-1:0] coreRdAddr,
  input  logic          coreRdHit,
  input  logic          coreRdIo,
  input  logic [DW-1:0] coreRdHitData,
  output logic          coreRdDone,
  output logic [DW-1:0] coreRdData,
  output logic          busReqValid,
  input  logic          busReqReady,
  output logic          busReqWrite,
  output logic [AW-1:0] busReqAddr,
  output logic [DW-1:0] busReqData,
  input  logic          busRspValid,
  input  logic [DW-1:0] busRspData
);

  wbStrobe_t strobe;
  wbStatus_t status;

  wrbuf_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .status      (status),
    .coreWrValid (coreWrValid),
    .coreRdValid (coreRdValid),
    .coreRdHit   (coreRdHit),
    .coreRdIo    (coreRdIo),
    .busReqReady (busReqReady),
    .busRspValid (busRspValid),
    .strobe      (strobe),
    .coreWrReady (coreWrReady),
    .coreRdDone  (coreRdDone),
    .busReqValid (busReqValid),
    .busReqWrite (busReqWrite)
  );

  wrbuf_dp #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .wrAddr    (coreWrAddr),
    .wrData    (coreWrData),
    .wrHit     (coreWrHit),
    .wrIo      (coreWrIo),
    .rdAddr    (coreRdAddr),
    .rdHitData (coreRdHitData),
    .rspData   (busRspData),
    .status    (status),
    .busAddr   (busReqAddr),
    .busData   (busReqData),
    .rdData    (coreRdData)
  );

endmodule

// File: rtl/wrbuf_bypass_chk.sv
module wrbuf_bypass_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          coreWrValid,
  input logic          coreWrReady,
  input logic          coreRdValid,
  input logic          coreRdHit,
  input logic          coreRdIo,
  input logic [DW-1:0] coreRdHitData,
  input logic          coreRdDone,
  input logic [DW-1:0] coreRdData,
  input logic          busReqValid,
  input logic          busReqReady,
  input logic          busReqWrite,
  input logic [AW-1:0] busReqAddr,
  input logic [DW-1:0] busReqData,
  input logic          busRspValid
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          outstanding;
  logic          outWrite;
  logic [CW-1:0] heldCnt;
  logic          wrIn;
  logic          wrOut;

  assign wrIn  = coreWrValid && coreWrReady;
  assign wrOut = outstanding && outWrite && busRspValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
      outWrite    <= 1'b0;
      heldCnt     <= '0;
    end else begin
      if (busReqValid && busReqReady) begin
        outstanding <= 1'b1;
        outWrite    <= busReqWrite;
      end else if (busRspValid) begin
        outstanding <= 1'b0;
      end
      if (wrIn && !wrOut)      heldCnt <= heldCnt + 1'b1;
      else if (!wrIn && wrOut) heldCnt <= heldCnt - 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    busReqValid && !busReqReady |=> busReqValid && $stable(busReqWrite)
      && $stable(busReqAddr) && $stable(busReqData)); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !busReqValid); // R7

  AST_HIT_READ_FAST: assert property (@(posedge clk) disable iff (rst)
    coreRdValid && coreRdHit && !coreRdIo |-> coreRdDone && (coreRdData == coreRdHitData)); // R3

  AST_WR_STALL_ON_READ: assert property (@(posedge clk) disable iff (rst)
    coreRdValid |-> !coreWrReady); // R2

  AST_WR_STALL_FULL: assert property (@(posedge clk) disable iff (rst)
    (heldCnt == CW'(DEPTH)) |-> !coreWrReady); // R2

  AST_IO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    busReqValid && !busReqWrite && coreRdIo |-> (heldCnt == '0)); // R5

  AST_READ_RSP_DONE: assert property (@(posedge clk) disable iff (rst)
    outstanding && !outWrite && busRspValid |-> coreRdDone); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !busReqValid); // R10

endmodule

bind wrbuf_bypass wrbuf_bypass_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .coreWrValid   (coreWrValid),
  .coreWrReady   (coreWrReady),
  .coreRdValid   (coreRdValid),
  .coreRdHit     (coreRdHit),
  .coreRdIo      (coreRdIo),
  .coreRdHitData (coreRdHitData),
  .coreRdDone    (coreRdDone),
  .coreRdData    (coreRdData),
  .busReqValid   (busReqValid),
  .busReqReady   (busReqReady),
  .busReqWrite   (busReqWrite),
  .busReqAddr    (busReqAddr),
  .busReqData    (busReqData),
  .busRspValid   (busRspValid)
);

// File: tb/test_wrbuf_bypass.sv
`timescale 1ns/1ps
module test_wrbuf_bypass;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coreWrValid = 1'b0;
  logic        coreWrReady;
  logic [31:0] coreWrAddr = '0;
  logic [31:0] coreWrData = '0;
  logic        coreWrHit = 1'b0;
  logic        coreWrIo = 1'b0;
  logic        coreRdValid = 1'b0;
  logic [31:0] coreRdAddr = '0;
  logic        coreRdHit = 1'b0;
  logic        coreRdIo = 1'b0;
  logic [31:0] coreRdHitData = '0;
  logic        coreRdDone;
  logic [31:0] coreRdData;
  logic        busReqValid;
  logic        busReqReady = 1'b0;
  logic        busReqWrite;
  logic [31:0] busReqAddr;
  logic [31:0] busReqData;
  logic        busRspValid = 1'b0;
  logic [31:0] busRspData = '0;

  always #2 clk = ~clk;

  wrbuf_bypass #(.AW(32), .DW(32), .DEPTH(DEPTH)) i_wrbuf_bypass (.*);

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // Model of writes accepted and not yet acknowledged, oldest first
  logic [31:0] pAddr [DEPTH];
  logic [31:0] pData [DEPTH];
  bit          pHit  [DEPTH];
  bit          pIo   [DEPTH];
  int          pCnt = 0;

  bit          outstanding = 0;
  bit          outWrite = 0;
  logic [31:0] outAddr = '0;
  int          lat = 0;
  bit          stallBus = 0;
  bit          reqSeen = 0;
  bit          reqSeenWrite = 0;

  function automatic logic [31:0] rdResp(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock cycle: drive bus side, check at negedge, update model after posedge
  task automatic cycle();
    bit wrTaken, hs, rspNow, fastNow, smpWrite, clean, match;
    logic [31:0] smpAddr;
    busRspValid = 1'b0;
    if (outstanding) begin
      if (lat == 0) begin
        busRspValid = 1'b1;
        busRspData  = outWrite ? 32'h0 : rdResp(outAddr);
      end else lat--;
    end
    busReqReady = stallBus ? 1'b0 : 1'($urandom % 2);
    @(negedge clk);
    fastNow = coreRdValid && coreRdHit && !coreRdIo;
    check(coreWrReady == ((pCnt < DEPTH) && !coreRdValid), "R2 write ready",
          32'(coreWrReady), 32'((pCnt < DEPTH) && !coreRdValid));
    if (outstanding) check(!busReqValid, "R7 request while outstanding", 32'(busReqValid), 0);
    if (busReqValid && !reqSeen) begin
      reqSeen = 1;
      reqSeenWrite = busReqWrite;
    end
    if (busReqValid && busReqWrite) begin
      check(pCnt > 0, "R1 write with empty model", 32'(pCnt), 1);
      if (pCnt > 0) begin
        check(busReqAddr == pAddr[0], "R1 write order addr", busReqAddr, pAddr[0]);
        check(busReqData == pData[0], "R1 write order data", busReqData, pData[0]);
      end
    end
    if (busReqValid && !busReqWrite) begin
      check(coreRdValid && !fastNow, "R4 read request without miss", 32'(coreRdValid), 1);
      check(busReqAddr == coreRdAddr, "R4 read address", busReqAddr, coreRdAddr);
      if (pCnt > 0) begin
        clean = 1; match = 0;
        for (int i = 0; i < pCnt; i++) begin
          if (!pHit[i] || pIo[i]) clean = 0;
          if (pAddr[i] == coreRdAddr) match = 1;
        end
        check(!coreRdIo, "R5 io read with buffered writes", 32'(pCnt), 0);
        check(clean && !match, "R4 bypass not allowed", {30'd0, clean, match}, 32'h2);
      end
    end
    if (fastNow) begin
      check(coreRdDone, "R3 hit read done", 32'(coreRdDone), 1);
      check(coreRdData == coreRdHitData, "R3 hit read data", coreRdData, coreRdHitData);
      check(!(busReqValid && !busReqWrite), "R3 hit read on bus", 32'(busReqValid), 0);
    end else if (busRspValid && !outWrite) begin
      check(coreRdDone, "R8 miss read done", 32'(coreRdDone), 1);
      check(coreRdData == busRspData, "R8 miss read data", coreRdData, busRspData);
    end else begin
      check(!coreRdDone, "R8 spurious done", 32'(coreRdDone), 0);
    end
    wrTaken  = coreWrValid && coreWrReady;
    hs       = busReqValid && busReqReady;
    rspNow   = busRspValid;
    smpWrite = busReqWrite;
    smpAddr  = busReqAddr;
    @(posedge clk);
    #1;
    busRspValid = 1'b0;
    if (rspNow) begin
      outstanding = 0;
      if (outWrite) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          pAddr[i] = pAddr[i+1]; pData[i] = pData[i+1];
          pHit[i]  = pHit[i+1];  pIo[i]   = pIo[i+1];
        end
        pCnt--;
      end else coreRdValid = 1'b0;
    end
    if (fastNow) coreRdValid = 1'b0;
    if (hs) begin
      outstanding = 1;
      outWrite = smpWrite;
      outAddr = smpAddr;
      lat = int'($urandom % 3);
    end
    if (wrTaken) begin
      pAddr[pCnt] = coreWrAddr; pData[pCnt] = coreWrData;
      pHit[pCnt]  = coreWrHit;  pIo[pCnt]   = coreWrIo;
      pCnt++;
      coreWrValid = 1'b0;
    end
  endtask

  task automatic putWrite(input logic [31:0] a, input bit hit, input bit io);
    coreWrValid = 1'b1; coreWrAddr = a; coreWrData = $urandom; coreWrHit = hit; coreWrIo = io;
  endtask

  task automatic putRead(input logic [31:0] a, input bit hit, input bit io);
    coreRdValid = 1'b1; coreRdAddr = a; coreRdHit = hit; coreRdIo = io; coreRdHitData = $urandom;
  endtask

  task automatic drain();
    for (int k = 0; k < 200; k++) begin
      if (pCnt == 0 && !coreRdValid && !coreWrValid && !outstanding) break;
      cycle();
    end
  endtask

  // Buffer one write, then present a read; report which kind reached the bus first
  task automatic orderCase(input bit wHit, input bit wIo, input logic [31:0] rAddr,
                           input bit rIo, input bit expWrite, input string req);
    putWrite(32'h10, wHit, wIo);
    cycle();
    putRead(rAddr, 1'b0, rIo);
    reqSeen = 0;
    for (int k = 0; k < 30 && !reqSeen; k++) cycle();
    check(reqSeen && (reqSeenWrite == expWrite), req, 32'(reqSeenWrite), 32'(expWrite));
    drain();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busReqValid, "R10 reset request", 32'(busReqValid), 0);
    check(coreWrReady, "R10 reset ready", 32'(coreWrReady), 1);
    check(!coreRdDone, "R10 reset done", 32'(coreRdDone), 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R6: clean, non-matching buffered write -> read goes first
    orderCase(1'b1, 1'b0, 32'h20, 1'b0, 1'b0, "R6 read wins over clean write");
    // R4: address match blocks the bypass
    orderCase(1'b1, 1'b0, 32'h10, 1'b0, 1'b1, "R4 matching address waits");
    // R4: a missing write blocks the bypass
    orderCase(1'b0, 1'b0, 32'h20, 1'b0, 1'b1, "R4 miss write blocks bypass");
    // R4: an I/O write blocks the bypass
    orderCase(1'b1, 1'b1, 32'h20, 1'b0, 1'b1, "R4 io write blocks bypass");
    // R5: I/O read waits behind a clean write
    orderCase(1'b1, 1'b0, 32'h20, 1'b1, 1'b1, "R5 io read waits");

    // R3: hitting read completes while the bus is busy with writes
    stallBus = 1;
    putWrite(32'h4, 1'b1, 1'b0);
    cycle();
    putRead(32'h4, 1'b1, 1'b0);
    cycle();
    check(!coreRdValid, "R3 hit read finished in one cycle", 32'(coreRdValid), 0);

    // R2: fill the buffer with the bus stalled
    for (int n = 0; n < DEPTH; n++) begin
      putWrite(32'(n * 8 + 64), 1'b1, 1'b0);
      for (int k = 0; k < 10 && coreWrValid; k++) cycle();
    end
    check(pCnt == DEPTH, "R2 buffer holds DEPTH writes", 32'(pCnt), 32'(DEPTH));
    putWrite(32'h100, 1'b1, 1'b0);
    cycle();
    cycle();
    check(coreWrValid, "R2 write refused when full", 32'(!coreWrValid), 0);

    // R10: reset clears the held writes
    rst = 1'b1; coreWrValid = 1'b0; stallBus = 0;
    busReqReady = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    pCnt = 0; outstanding = 0;
    @(negedge clk);
    check(!busReqValid, "R10 no request after reset", 32'(busReqValid), 0);
    check(coreWrReady, "R10 buffer empty after reset", 32'(coreWrReady), 1);
    @(posedge clk); #1;
    for (int k = 0; k < 3; k++) cycle();
    check(!busReqValid && pCnt == 0, "R10 no stale write drained", 32'(busReqValid), 0);

    // Random mixed traffic on a small address set
    for (int c = 0; c < 4000; c++) begin
      if (!coreWrValid && ($urandom % 3 == 0))
        putWrite(32'(($urandom % 8) * 4), ($urandom % 4) != 0, ($urandom % 6) == 0);
      if (!coreRdValid && ($urandom % 5 == 0))
        putRead(32'(($urandom % 8) * 4), ($urandom % 3) == 0, ($urandom % 5) == 0);
      cycle();
    end
    drain();
    check(pCnt == 0 && !outstanding, "R1 all writes drained", 32'(pCnt), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule